// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block keeps the pending-interrupt state for a small timer group made of an 8-bit timer and a 16-bit timer. Three sticky flags record events: the 8-bit timer's overflow, the 8-bit timer's compare match, and the 16-bit timer's overflow. Each timer reports its events as single-cycle pulses. For each overflow flag, a per-timer PWM-mode input selects which pulse sets it. In normal counting the flag is set by the wrap pulse. In PWM counting it is set by the pulse the timer gives when its count leaves zero.

A flag stays set until the CPU clears it. The CPU can acknowledge that flag's vector with a one-hot pulse, or it can write a one to the flag's bit over the register port. A set event that arrives in the same cycle as a clear takes priority, so no event is lost. Each flag is ANDed with its own enable bit and with the global interrupt enable to drive one request line. A simple bus port reads and writes the flag and enable registers. Reads are combinational on the address, and writes take effect at the clock edge.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset all three flags and all three enable bits are zero, both registers read zero, and no request line is high.
- R2: With the timer's PWM-mode input low, a wrap pulse sets that timer's overflow flag at the next clock edge, and a leave-zero pulse has no effect. The 8-bit overflow flag is at bit 0 and the 16-bit overflow flag is at bit 2.
- R3: With the timer's PWM-mode input high, a leave-zero pulse sets that timer's overflow flag at the next clock edge, and a wrap pulse has no effect.
- R4: A compare-match pulse sets the compare flag at bit 1 at the next clock edge.
- R5: A write to the flag register (address 0) clears at the next edge every flag whose data bit is one. Flags whose data bit is zero are left unchanged, and the write never sets a flag.
- R6: An acknowledge pulse on bit i of the acknowledge vector clears flag i at the next edge and leaves the other flags unchanged. At most one acknowledge bit is high in any cycle.
- R7: When a set pulse and a clear (acknowledge or write-one) reach the same flag in the same cycle, the flag is one after the edge.
- R8: Request line i is high in the same cycle exactly when the global enable, enable bit i and flag i are all one.
- R9: A write to the enable register (address 1) loads bits 2..0 of the data. Reading address 1 returns the enables in bits 2..0 and zero in the upper bits.
- R10: Reading the flag register returns the flags in bits 2..0 and zero above. Other addresses read zero. A write to any other address, or a write with select low, changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| t8_pwm | input | 1 | 8-bit timer is in PWM mode |
| t8_wrap | input | 1 | 8-bit timer wrap pulse |
| t8_leave_zero | input | 1 | 8-bit timer left-zero pulse |
| t8_match | input | 1 | 8-bit timer compare-match pulse |
| t16_pwm | input | 1 | 16-bit timer is in PWM mode |
| t16_wrap | input | 1 | 16-bit timer wrap pulse |
| t16_leave_zero | input | 1 | 16-bit timer left-zero pulse |
| glob_ie | input | 1 | Global interrupt enable |
| ack | input | 3 | One-hot vector acknowledge, bit i for flag i |
| bus_sel | input | 1 | Register port select |
| bus_we | input | 1 | Write enable |
| bus_addr | input | ADDR_W (2) | Register address |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data, combinational on address |
| irq_req | output | 3 | Request lines, bit i for flag i |

## Verification
The assertions assume that the acknowledge vector is one-hot or zero, because a CPU serves one vector at a time. One assertion states this contract, and the bench never raises two acknowledge bits together. The set-priority and hold properties treat a pulse input as an event in every cycle it is high, so they need no pulse-width assumption. Even so, the stimulus raises each event for exactly one cycle, and it drives every input half a cycle away from the sampling edge. The same-cycle collision sweep drives each source's set, acknowledge and write-one in all combinations. During that sweep the other flags are held at one, which shows they are left untouched.

// File: rtl/tifr_pkg.sv
package tifr_pkg;
   localparam int NUM_SRC     = 3;
   localparam int IDX_T8_OVF  = 0;
   localparam int IDX_T8_CMP  = 1;
   localparam int IDX_T16_OVF = 2;

   typedef enum logic [1:0] {
      REG_NONE   = 2'd0,
      REG_FLAGS  = 2'd1,
      REG_ENABLE = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/tifr_event_sel.sv
module tifr_event_sel #(
   parameter bit HAS_PWM = 1'b1
) (
   input  logic pwm_mode,
   input  logic wrap_pulse,
   input  logic leave_zero_pulse,
   output logic set_pulse
);
   generate
      if (HAS_PWM) begin : g_pwm
         assign set_pulse = pwm_mode ? leave_zero_pulse : wrap_pulse;
      end else begin : g_plain
         assign set_pulse = wrap_pulse;
      end
   endgenerate
endmodule

// File: rtl/tifr_flag_bit.sv
module tifr_flag_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_pulse,
   input  logic ack_pulse,
   input  logic w1c_pulse,
   output logic flag_q
);
   logic clr;
   assign clr = ack_pulse | w1c_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (set_pulse) flag_q <= 1'b1;
      else if (clr)       flag_q <= 1'b0;
   end

   // R7: set has priority over any clear
   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse |=> flag_q);
   // R5: write-one clears when no set
   assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c_pulse && !set_pulse) |=> !flag_q);
   // R6: acknowledge clears when no set
   assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_pulse && !set_pulse) |=> !flag_q);
   // R5: no event leaves the flag alone
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_pulse && !ack_pulse && !w1c_pulse) |=> $stable(flag_q));
endmodule

// File: rtl/tifr_reg_port.sv
module tifr_reg_port
   import tifr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int NUM         = 3,
   parameter int FLAG_ADDR   = 0,
   parameter int ENABLE_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [NUM-1:0]    flags,
   output logic [NUM-1:0]    flag_w1c,
   output logic [NUM-1:0]    en_q,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);
   localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(ENABLE_ADDR);

   reg_sel_e sel;
   logic     wr;

   always_comb begin
      if (bus_addr == FLAG_A)     sel = REG_FLAGS;
      else if (bus_addr == EN_A)  sel = REG_ENABLE;
      else                        sel = REG_NONE;
   end

   assign wr = bus_sel & bus_we;

   always_comb begin
      flag_w1c = '0;
      if (wr && sel == REG_FLAGS) flag_w1c = bus_wdata[NUM-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       en_q <= '0;
      else if (wr && sel == REG_ENABLE) en_q <= bus_wdata[NUM-1:0];
   end

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         REG_FLAGS:  bus_rdata[NUM-1:0] = flags;
         REG_ENABLE: bus_rdata[NUM-1:0] = en_q;
         default:    bus_rdata = '0;
      endcase
   end

   // R9: enable register loads written data
   assert_en_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == EN_A) |=> en_q == $past(bus_wdata[NUM-1:0]));
   // R10: writes elsewhere leave enables unchanged
   assert_en_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && bus_addr == EN_A) |=> $stable(en_q));
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
   import tifr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int FLAG_ADDR   = 0,
   parameter int ENABLE_ADDR = 1,
   parameter bit T8_PWM      = 1'b1,
   parameter bit T16_PWM     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              t8_pwm,
   input  logic              t8_wrap,
   input  logic              t8_leave_zero,
   input  logic              t8_match,
   input  logic              t16_pwm,
   input  logic              t16_wrap,
   input  logic              t16_leave_zero,
   input  logic              glob_ie,
   input  logic [NUM_SRC-1:0] ack,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_SRC-1:0] irq_req
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (DATA_W < NUM_SRC) begin : g_bad_width
         $error("DATA_W must hold all flag bits");
      end
      if (FLAG_ADDR == ENABLE_ADDR) begin : g_bad_addr
         $error("flag and enable registers need distinct addresses");
      end
      if (FLAG_ADDR >= ADDR_SPAN || ENABLE_ADDR >= ADDR_SPAN) begin : g_bad_span
         $error("register address outside ADDR_W range");
      end
   endgenerate

   logic [NUM_SRC-1:0] set_pulse;
   logic [NUM_SRC-1:0] flag_q;
   logic [NUM_SRC-1:0] flag_w1c;
   logic [NUM_SRC-1:0] en_q;

   tifr_event_sel #(.HAS_PWM(T8_PWM)) u_sel_t8 (
      .pwm_mode(t8_pwm), .wrap_pulse(t8_wrap),
      .leave_zero_pulse(t8_leave_zero), .set_pulse(set_pulse[IDX_T8_OVF]));

   tifr_event_sel #(.HAS_PWM(T16_PWM)) u_sel_t16 (
      .pwm_mode(t16_pwm), .wrap_pulse(t16_wrap),
      .leave_zero_pulse(t16_leave_zero), .set_pulse(set_pulse[IDX_T16_OVF]));

   assign set_pulse[IDX_T8_CMP] = t8_match;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_flag
         tifr_flag_bit u_bit (
            .clk(clk), .rst_n(rst_n),
            .set_pulse(set_pulse[gi]), .ack_pulse(ack[gi]),
            .w1c_pulse(flag_w1c[gi]), .flag_q(flag_q[gi]));
         assign irq_req[gi] = glob_ie & en_q[gi] & flag_q[gi];
      end
   endgenerate

   tifr_reg_port #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM(NUM_SRC),
      .FLAG_ADDR(FLAG_ADDR), .ENABLE_ADDR(ENABLE_ADDR)
   ) u_port (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flags(flag_q),
      .flag_w1c(flag_w1c), .en_q(en_q), .bus_rdata(bus_rdata));

   // R6: at most one vector acknowledged per cycle
   assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack));
   // R8: no request without global enable
   assert_req_needs_glob_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req != '0) |-> glob_ie);
   // R2: normal-mode wrap sets the 8-bit overflow flag
   assert_t8_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!t8_pwm && t8_wrap) |=> flag_q[IDX_T8_OVF]);
   // R3: PWM-mode leave-zero sets the 16-bit overflow flag
   assert_t16_pwm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (t16_pwm && t16_leave_zero) |=> flag_q[IDX_T16_OVF]);
   // R4: compare match sets bit 1
   assert_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      t8_match |=> flag_q[IDX_T8_CMP]);
endmodule

// File: tb/tmr_irq_flags_test.sv
module tmr_irq_flags_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       t8_pwm = 0, t8_wrap = 0, t8_leave_zero = 0, t8_match = 0;
   logic       t16_pwm = 0, t16_wrap = 0, t16_leave_zero = 0;
   logic       glob_ie = 0;
   logic [2:0] ack = '0;
   logic       bus_sel = 0, bus_we = 0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [2:0] irq_req;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #4 clk = ~clk;

   tmr_irq_flags uut (
      .clk(clk), .rst_n(rst_n), .t8_pwm(t8_pwm), .t8_wrap(t8_wrap),
      .t8_leave_zero(t8_leave_zero), .t8_match(t8_match), .t16_pwm(t16_pwm),
      .t16_wrap(t16_wrap), .t16_leave_zero(t16_leave_zero), .glob_ie(glob_ie),
      .ack(ack), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      tick();
      bus_sel = 0; bus_we = 0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic drive_set(input int src, input bit v);
      case (src)
         0: t8_wrap  = v;
         1: t8_match = v;
         default: t16_wrap = v;
      endcase
   endtask

   task automatic set_flags(input logic [2:0] m);
      bus_write(2'd0, 8'hFF);
      t8_pwm = 0; t16_pwm = 0;
      t8_wrap = m[0]; t8_match = m[1]; t16_wrap = m[2];
      tick();
      t8_wrap = 0; t8_match = 0; t16_wrap = 0;
   endtask

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset state
      bus_read(2'd0, rd); check("R1 flags after reset", rd, 8'h00);
      bus_read(2'd1, rd); check("R1 enables after reset", rd, 8'h00);
      check("R1 no request after reset", {5'd0, irq_req}, 8'h00);

      // R2/R3: event selection per timer and mode
      for (int tm = 0; tm < 2; tm++)
         for (int pw = 0; pw < 2; pw++)
            for (int kind = 0; kind < 2; kind++) begin
               logic [7:0] exp;
               set_flags(3'b000);
               t8_pwm = pw[0]; t16_pwm = pw[0];
               if (tm == 0) begin
                  if (kind == 0) t8_wrap = 1; else t8_leave_zero = 1;
               end else begin
                  if (kind == 0) t16_wrap = 1; else t16_leave_zero = 1;
               end
               tick();
               t8_wrap = 0; t8_leave_zero = 0; t16_wrap = 0; t16_leave_zero = 0;
               exp = ((pw == 1) == (kind == 1)) ? (tm == 0 ? 8'h01 : 8'h04) : 8'h00;
               bus_read(2'd0, rd);
               check(pw == 1 ? "R3 PWM-mode overflow select" : "R2 normal-mode overflow select", rd, exp);
               t8_pwm = 0; t16_pwm = 0;
            end

      // R4: compare match
      set_flags(3'b000);
      t8_match = 1; tick(); t8_match = 0;
      bus_read(2'd0, rd); check("R4 compare match sets bit 1", rd, 8'h02);

      // R5/R6/R7: collision sweep per source
      for (int src = 0; src < 3; src++)
         for (int c = 0; c < 16; c++) begin
            logic [2:0] init;
            logic       tgt;
            init = 3'b111;
            init[src] = c[0];
            set_flags(init);
            drive_set(src, c[1]);
            ack[src] = c[2];
            if (c[3]) begin
               bus_sel = 1; bus_we = 1; bus_addr = 2'd0;
               bus_wdata = 8'h00; bus_wdata[src] = 1'b1;
            end
            tick();
            drive_set(src, 1'b0); ack = '0;
            bus_sel = 0; bus_we = 0; bus_wdata = '0;
            tgt = c[1] | (c[0] & ~c[2] & ~c[3]);
            init[src] = tgt;
            bus_read(2'd0, rd);
            if (c[1] && (c[2] || c[3]))
               check("R7 set beats clear", rd, {5'd0, init});
            else if (c[2])
               check("R6 acknowledge clears one flag", rd, {5'd0, init});
            else
               check("R5 write-one clear / write-zero keep", rd, {5'd0, init});
         end

      // R8: request gating sweep
      for (int g = 0; g < 2; g++)
         for (int en = 0; en < 8; en++)
            for (int fl = 0; fl < 8; fl++) begin
               bus_write(2'd1, 8'(en));
               set_flags(3'(fl));
               glob_ie = g[0];
               #1 check("R8 request gating", {5'd0, irq_req},
                        g == 1 ? 8'(en & fl) : 8'h00);
               glob_ie = 0;
            end

      // R9: enable register width
      bus_write(2'd1, 8'hFF);
      bus_read(2'd1, rd); check("R9 enable readback masks upper bits", rd, 8'h07);
      bus_write(2'd1, 8'h05);
      bus_read(2'd1, rd); check("R9 enable readback pattern", rd, 8'h05);

      // R10: flag readback, unmapped addresses, unselected writes
      set_flags(3'b111);
      bus_read(2'd0, rd); check("R10 flag readback masks upper bits", rd, 8'h07);
      bus_write(2'd2, 8'hFF);
      bus_write(2'd3, 8'hFF);
      bus_sel = 0; bus_we = 1; bus_addr = 2'd0; bus_wdata = 8'hFF; tick();
      bus_addr = 2'd1; bus_wdata = 8'h00; tick();
      bus_we = 0; bus_wdata = '0;
      bus_read(2'd0, rd); check("R10 flags kept after stray writes", rd, 8'h07);
      bus_read(2'd1, rd); check("R10 enables kept after stray writes", rd, 8'h05);
      bus_read(2'd2, rd); check("R10 address 2 reads zero", rd, 8'h00);
      bus_read(2'd3, rd); check("R10 address 3 reads zero", rd, 8'h00);

      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule